// File: doc/BRIEF.md
# SPI Slave Command Front End

This block is the serial side of a register-access port. It runs entirely on the SPI serial clock and receives two-byte commands while chip select is low. The first byte is an address byte whose top bit selects read or write and whose low seven bits give a register index. The second byte is a data field. When a whole command has arrived, the block presents it on a parallel bus and raises a request toward the core domain. It holds that request and the bus unchanged until the core acknowledges.

While a request is outstanding, a new frame is rejected: it produces no request and leaves the bus untouched. During the data byte of every frame the slave shifts out one of two things on MISO. If the core marked its return data ready and no earlier command is pending, it sends the return data. Otherwise it sends a fixed busy packet. Clock-domain synchronisation and the core controller sit outside this block.

Top module: `spi_cmd_frontend`

## Requirements
- R1: After asynchronous reset (rst_ni low) the request output is low, the command bus (rw, index, data) is all zeros, and MISO is low.
- R2: A frame is 16 bits, most significant bit first, with MOSI sampled on rising SCLK edges. The first 8 bits form the address byte, where bit 7 is rw and bits 6:0 are the index. The last 8 bits are the data field. On the 16th rising edge the decoded command appears on cmd_rw_o, cmd_idx_o and cmd_data_o.
- R3: An accepted frame raises cmd_req_o on its 16th rising edge. The request stays high until cmd_ack_i is sampled high on a rising SCLK edge, and it goes low on that edge.
- R4: A frame is rejected if cmd_req_o is high at its 8th rising edge. A rejected frame raises no new request and does not alter the command bus.
- R5: While cmd_req_o is high, cmd_rw_o, cmd_idx_o and cmd_data_o do not change.
- R6: In the data phase MISO carries rd_data_i MSB first, changing on falling SCLK edges, provided the frame is accepted and rd_ready_i is high at the 8th rising edge. rd_data_i is captured on that edge, so later changes to rd_data_i do not affect the byte sent.
- R7: If rd_ready_i is low at the 8th rising edge, or the frame is rejected, the data phase sends the busy packet 0xFF and rd_data_i is ignored.
- R8: MISO is low during the address phase of a frame and whenever cs_ni is high.
- R9: Raising cs_ni at any point aborts a partial frame. It clears the bit count to zero and raises no request, so the next frame is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | SPI serial clock; clocks all logic |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low; high aborts the frame |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| cmd_req_o | output | 1 | Command request, held until acknowledged |
| cmd_ack_i | input | 1 | Core acknowledge, already in the SCLK domain |
| cmd_rw_o | output | 1 | Read/write flag of the held command |
| cmd_idx_o | output | 7 | Register index of the held command |
| cmd_data_o | output | 8 | Data field of the held command |
| rd_data_i | input | 8 | Return data from the core |
| rd_ready_i | input | 1 | Return data valid flag |

## Verification
The bench drives MOSI 1 ns after each falling edge. The command bus and request are due one register stage after the 16th rising edge, so the bench reads them 1 ns after that edge. Each MISO data bit is due at the falling edge that follows the rising edge which consumed the previous bit, so the bench samples it 1 ns after that falling edge. Acknowledge takes effect on the first rising edge that sees it high, and the request is checked 1 ns after that edge. A sweep of 32 computed commands covers both rw values, ready high and low, and varied bytes. Directed frames cover rejection, a mid-frame change of rd_data_i, and abort.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int unsigned DEF_IDX_W  = 7;
  localparam int unsigned DEF_DATA_W = 8;

  function automatic int unsigned frame_bits(input int unsigned idx_w, input int unsigned data_w);
    return idx_w + 1 + data_w;
  endfunction

  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/spi_bit_counter.sv
module spi_bit_counter #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned CNT_W  = spi_cmd_pkg::cnt_bits(FRAME_W)
) (
  input  logic             sclk_i,
  input  logic             frame_rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_o,
  output logic             last_o,
  output logic             data_ph_o
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] LOAD_C = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_C = CNT_W'(ADDR_W);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge sclk_i or negedge frame_rst_ni) begin
    if (!frame_rst_ni)       cnt_q <= '0;
    else if (cnt_q == LAST_C) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign load_o    = (cnt_q == LOAD_C);
  assign last_o    = (cnt_q == LAST_C);
  assign data_ph_o = (cnt_q >= DATA_C);
endmodule

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               sclk_i,
  input  logic               frame_rst_ni,
  input  logic               mosi_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-2:0] sr_q;

  always_ff @(posedge sclk_i or negedge frame_rst_ni) begin
    if (!frame_rst_ni) sr_q <= '0;
    else               sr_q <= {sr_q[FRAME_W-3:0], mosi_i};
  end

  // full frame as seen on the completing edge
  assign frame_o = {sr_q, mosi_i};
endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
  parameter int unsigned        DATA_W = 8,
  parameter logic [DATA_W-1:0] BUSY_C = '1
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              load_i,
  input  logic              data_ph_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              miso_o
);
  logic [DATA_W-1:0] sr_q;
  logic              miso_q;

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni)        sr_q <= '0;
    else if (load_i)    sr_q <= busy_i ? BUSY_C : rd_data_i;
    else if (data_ph_i) sr_q <= {sr_q[DATA_W-2:0], 1'b0};
    else                sr_q <= '0;
  end

  // launch on falling edge, mode 0
  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) miso_q <= 1'b0;
    else         miso_q <= sr_q[DATA_W-1];
  end

  assign miso_o = miso_q & ~cs_ni;
endmodule

// File: rtl/spi_cmd_hold.sv
module spi_cmd_hold #(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned FRAME_W = IDX_W + 1 + DATA_W
) (
  input  logic               sclk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               last_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               ack_i,
  output logic               req_o,
  output logic               rw_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [DATA_W-1:0]  data_o
);
  logic              req_q, reject_q, rw_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  assign accept = last_i & ~reject_q;

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni)     reject_q <= 1'b0;
    else if (load_i) reject_q <= req_q;
  end

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni)     req_q <= 1'b0;
    else if (accept) req_q <= 1'b1;
    else if (ack_i)  req_q <= 1'b0;
  end

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rw_q   <= 1'b0;
      idx_q  <= '0;
      data_q <= '0;
    end else if (accept) begin
      rw_q   <= frame_i[FRAME_W-1];
      idx_q  <= frame_i[FRAME_W-2 -: IDX_W];
      data_q <= frame_i[DATA_W-1:0];
    end
  end

  assign req_o  = req_q;
  assign rw_o   = rw_q;
  assign idx_o  = idx_q;
  assign data_o = data_q;
endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend #(
  parameter int unsigned        IDX_W  = spi_cmd_pkg::DEF_IDX_W,
  parameter int unsigned        DATA_W = spi_cmd_pkg::DEF_DATA_W,
  parameter logic [DATA_W-1:0] BUSY_C = '1
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              cmd_req_o,
  input  logic              cmd_ack_i,
  output logic              cmd_rw_o,
  output logic [IDX_W-1:0]  cmd_idx_o,
  output logic [DATA_W-1:0] cmd_data_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_ready_i
);
  localparam int unsigned ADDR_W  = IDX_W + 1;
  localparam int unsigned FRAME_W = spi_cmd_pkg::frame_bits(IDX_W, DATA_W);
  localparam int unsigned CNT_W   = spi_cmd_pkg::cnt_bits(FRAME_W);

  logic               frame_rst_n;
  logic [CNT_W-1:0]   bit_cnt;
  logic               load, last, data_ph, busy;
  logic [FRAME_W-1:0] frame;

  // chip select high acts as asynchronous frame abort
  assign frame_rst_n = rst_ni & ~cs_ni;
  assign busy        = cmd_req_o | ~rd_ready_i;

  spi_bit_counter #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) u_cnt (
    .sclk_i(sclk_i), .frame_rst_ni(frame_rst_n), .cnt_o(bit_cnt),
    .load_o(load), .last_o(last), .data_ph_o(data_ph)
  );

  spi_rx_shifter #(.FRAME_W(FRAME_W)) u_rx (
    .sclk_i(sclk_i), .frame_rst_ni(frame_rst_n), .mosi_i(mosi_i), .frame_o(frame)
  );

  spi_tx_shifter #(.DATA_W(DATA_W), .BUSY_C(BUSY_C)) u_tx (
    .sclk_i(sclk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .load_i(load),
    .data_ph_i(data_ph), .busy_i(busy), .rd_data_i(rd_data_i), .miso_o(miso_o)
  );

  spi_cmd_hold #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_hold (
    .sclk_i(sclk_i), .rst_ni(rst_ni), .load_i(load), .last_i(last),
    .frame_i(frame), .ack_i(cmd_ack_i), .req_o(cmd_req_o),
    .rw_o(cmd_rw_o), .idx_o(cmd_idx_o), .data_o(cmd_data_o)
  );
endmodule

// File: rtl/spi_cmd_frontend_chk.sv
module spi_cmd_frontend_chk #(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned FRAME_W = 16
) (
  input logic              sclk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              cmd_ack_i,
  input logic              cmd_req_o,
  input logic              cmd_rw_o,
  input logic [IDX_W-1:0]  cmd_idx_o,
  input logic [DATA_W-1:0] cmd_data_o,
  input logic [CNT_W-1:0]  bit_cnt
);
  assert_req_hold_R3: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    cmd_req_o && !cmd_ack_i |=> cmd_req_o);

  assert_req_clear_R3: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    cmd_req_o && cmd_ack_i |=> !cmd_req_o);

  assert_req_at_end_R2: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    $rose(cmd_req_o) |-> $past(bit_cnt) == CNT_W'(FRAME_W - 1));

  assert_bus_frozen_R5: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    cmd_req_o |=> $stable({cmd_rw_o, cmd_idx_o, cmd_data_o}));

  assert_abort_clear_R9: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    cs_ni |-> bit_cnt == '0);
endmodule

bind spi_cmd_frontend spi_cmd_frontend_chk #(
  .IDX_W(IDX_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .FRAME_W(FRAME_W)
) u_chk (
  .sclk_i(sclk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .cmd_ack_i(cmd_ack_i),
  .cmd_req_o(cmd_req_o), .cmd_rw_o(cmd_rw_o), .cmd_idx_o(cmd_idx_o),
  .cmd_data_o(cmd_data_o), .bit_cnt(bit_cnt)
);

// File: tb/sim_spi_cmd_frontend.sv
`timescale 1ns/100ps
module sim_spi_cmd_frontend;
  logic       sclk_i = 1'b0, rst_ni = 1'b0, cs_ni = 1'b1, mosi_i = 1'b0;
  logic       cmd_ack_i = 1'b0, rd_ready_i = 1'b0;
  logic [7:0] rd_data_i = '0;
  logic       miso_o, cmd_req_o, cmd_rw_o;
  logic [6:0] cmd_idx_o;
  logic [7:0] cmd_data_o;

  int n_chk = 0, n_bad = 0;

  spi_cmd_frontend u0 (.*);

  always #2 sclk_i = ~sclk_i;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic addr_hi;

  // full frame; returns data-phase MISO byte; flip_at toggles rd_data_i mid-frame
  task automatic send_frame(input logic [15:0] f, input int flip_at, output logic [7:0] mb);
    mb = '0;
    addr_hi = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge sclk_i); #1;
      if (i >= 1 && i < 8 && miso_o) addr_hi = 1'b1;
      if (i >= 8) mb[15-i] = miso_o;
      cs_ni  = 1'b0;
      mosi_i = f[15-i];
      if (i == flip_at) rd_data_i = ~rd_data_i;
    end
    @(posedge sclk_i); #1;
  endtask

  task automatic end_frame();
    @(negedge sclk_i); #1;
    cs_ni = 1'b1;
  endtask

  task automatic do_ack();
    @(negedge sclk_i); #1;
    cmd_ack_i = 1'b1;
    @(posedge sclk_i); #1;
    chk("R3 ack clears req", cmd_req_o, 0);
    @(negedge sclk_i); #1;
    cmd_ack_i = 1'b0;
  endtask

  initial begin
    logic [7:0] mb;
    logic [15:0] f;
    #9;
    chk("R1 req", cmd_req_o, 0);
    chk("R1 bus", {cmd_rw_o, cmd_idx_o, cmd_data_o}, 0);
    chk("R1 miso", miso_o, 0);
    @(negedge sclk_i); #1;
    rst_ni = 1'b1;
    repeat (2) @(negedge sclk_i);

    // sweep of computed commands
    for (int k = 0; k < 32; k++) begin
      logic       rw, rdy;
      logic [6:0] idx;
      logic [7:0] dat, rd;
      rw  = k[0];
      idx = 7'((k * 37 + 5) & 8'h7f);
      dat = 8'((k * 73 + 11) & 8'hff);
      rd  = 8'((k * 29) ^ 8'h5a);
      rdy = k[1] | k[3];
      @(negedge sclk_i); #1;
      rd_data_i  = rd;
      rd_ready_i = rdy;
      send_frame({rw, idx, dat}, -1, mb);
      chk("R3 req raised", cmd_req_o, 1);
      chk("R2 rw", cmd_rw_o, rw);
      chk("R2 idx", cmd_idx_o, idx);
      chk("R2 data", cmd_data_o, dat);
      chk(rdy ? "R6 read byte" : "R7 busy byte", mb, rdy ? rd : 8'hff);
      chk("R8 addr phase miso", addr_hi, 0);
      end_frame();
      chk("R8 cs high miso", miso_o, 0);
      chk("R3 req held", cmd_req_o, 1);
      do_ack();
    end

    // rejection while outstanding, ready high
    rd_ready_i = 1'b1;
    rd_data_i  = 8'h3c;
    send_frame(16'h8a_55, -1, mb);
    end_frame();
    send_frame(16'h21_99, -1, mb);
    chk("R4 rejected req stays", cmd_req_o, 1);
    chk("R5 bus frozen", {cmd_rw_o, cmd_idx_o, cmd_data_o}, 16'h8a55);
    chk("R7 busy on reject", mb, 8'hff);
    end_frame();
    repeat (3) @(posedge sclk_i);
    #1;
    chk("R5 bus still frozen", {cmd_rw_o, cmd_idx_o, cmd_data_o}, 16'h8a55);
    do_ack();

    // rd_data_i changes after capture edge
    rd_data_i = 8'hc3;
    send_frame(16'h13_24, 10, mb);
    chk("R6 captured at 8th edge", mb, 8'hc3);
    end_frame();
    do_ack();

    // abort partial frame
    f = 16'hff_ff;
    for (int i = 0; i < 10; i++) begin
      @(negedge sclk_i); #1;
      cs_ni  = 1'b0;
      mosi_i = f[15-i];
    end
    end_frame();
    repeat (4) @(posedge sclk_i);
    #1;
    chk("R9 no req on abort", cmd_req_o, 0);
    chk("R9 bus untouched", {cmd_rw_o, cmd_idx_o, cmd_data_o}, 16'h1324);
    rd_ready_i = 1'b0;
    send_frame(16'h42_81, -1, mb);
    chk("R9 clean restart", {cmd_req_o, cmd_rw_o, cmd_idx_o, cmd_data_o}, 17'h14281);
    chk("R7 not ready busy", mb, 8'hff);
    end_frame();
    do_ack();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule